// File: doc/BRIEF.md
# FIFO Status and Interrupt Unit

This block sits next to the transmit and receive FIFOs of a serial controller. It takes the fill counts that the FIFOs report, together with the push and pop strobes at their edges, and turns them into a status word, five interrupt causes, a single interrupt line and two DMA request lines. The FIFO storage, the shift engine and the bus decoding are outside it. Register traffic reaches it as already-decoded word addresses with write data and a separate combinational read port.

Software programs a threshold for each FIFO, an interrupt mask and two DMA levels. It then services the controller either from the interrupt or from the DMA requests. Three causes are sticky error flags that software clears through a clear register. The two threshold causes follow the FIFO levels directly. Every threshold and level register refuses a value equal to or larger than the FIFO depth. Software can therefore find the depth by writing growing values and checking when the readback stops matching.

Register word addresses: 0 status, 1 transmit level, 2 receive level, 3 transmit threshold, 4 receive threshold, 5 mask, 6 raw causes, 7 masked causes, 8 clear (write only), 9 DMA enable, 10 transmit DMA level, 11 receive DMA level. A read of any other address, or of address 8, returns zero. All registers reset to zero.

Top module: `fifoStatUnit`

## Requirements
- R1: The status word has busy in bit 0, transmit full (level equal to DEPTH) in bit 1, transmit empty (level 0) in bit 2, receive empty in bit 3 and receive full in bit 4. It follows the inputs in the same cycle, and it is readable at address 0.
- R2: A write to the transmit threshold (3), receive threshold (4), transmit DMA level (10) or receive DMA level (11) takes effect only when the written value is below DEPTH. Otherwise the old value stays, and the readback shows the value that was kept.
- R3: Raw cause bit 0 (transmit low) is set while the transmit level is at or below the transmit threshold.
- R4: Raw cause bit 4 (receive high) is set while the receive level is above the receive threshold.
- R5: A transmit push while the transmit level equals DEPTH sets the sticky raw bit 1 (transmit overflow) from the next cycle on.
- R6: A receive pop while the receive level is 0 sets the sticky raw bit 2 (receive underflow). A receive push while the receive level equals DEPTH sets the sticky raw bit 3 (receive overflow).
- R7: Writing the clear register (8) with bit 0 set clears all three sticky bits. Bit 1 clears the underflow, bit 2 clears the receive overflow and bit 3 clears the transmit overflow. A set event in the same cycle wins over a clear.
- R8: The masked causes (read at 7) equal the raw causes (read at 6) ANDed with the 5-bit mask (read and written at 5).
- R9: The interrupt output is the OR of the masked causes, registered, so it changes one cycle after the causes change.
- R10: The transmit DMA request is high when DMA enable bit 1 is set and the transmit level is at or below the transmit DMA level. The receive DMA request is high when enable bit 0 is set and the receive level is above the receive DMA level. Both are combinational.
- R11: After reset, the interrupt line, both DMA requests and every writable and sticky register are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busy | input | 1 | Serial engine busy flag |
| txLevel | input | LVLW | Transmit FIFO fill count, 0..DEPTH |
| rxLevel | input | LVLW | Receive FIFO fill count, 0..DEPTH |
| txPush | input | 1 | Write strobe into the transmit FIFO |
| rxPush | input | 1 | Write strobe into the receive FIFO |
| rxPop | input | 1 | Read strobe from the receive FIFO |
| regWrEn | input | 1 | Register write enable |
| regWrAddr | input | ADDRW | Register write word address |
| regWrData | input | DATAW | Register write data |
| regRdAddr | input | ADDRW | Register read word address |
| regRdData | output | DATAW | Register read data, combinational |
| statusWord | output | 5 | Status flags |
| irq | output | 1 | Registered interrupt line |
| txDmaReq | output | 1 | Transmit DMA request |
| rxDmaReq | output | 1 | Receive DMA request |

## Verification
The assertions assume that the level inputs never exceed DEPTH. They also assume that a level of DEPTH or 0 reflects a really full or empty FIFO, so a push or pop at that level counts as a fault event. The stimulus draws levels only from 0..DEPTH and biases them toward both ends, so that overflow and underflow strobes occur often. Register writes mix in-range values, values just above DEPTH and random clear patterns, and every cycle is compared against a reference model of the register state.

// File: rtl/fifoStatPkg.sv
package fifoStatPkg;

  localparam int ADDR_STATUS = 0;
  localparam int ADDR_TXLVL  = 1;
  localparam int ADDR_RXLVL  = 2;
  localparam int ADDR_TXTHR  = 3;
  localparam int ADDR_RXTHR  = 4;
  localparam int ADDR_MASK   = 5;
  localparam int ADDR_RAW    = 6;
  localparam int ADDR_MASKED = 7;
  localparam int ADDR_CLEAR  = 8;
  localparam int ADDR_DMA    = 9;
  localparam int ADDR_TXDL   = 10;
  localparam int ADDR_RXDL   = 11;

  localparam int NCAUSE = 5;

  // write strobes from control to datapath
  typedef struct packed {
    logic wrTxThr;
    logic wrRxThr;
    logic wrMask;
    logic wrClr;
    logic wrDma;
    logic wrTxDl;
    logic wrRxDl;
  } ctlStrobeT;

endpackage

// File: rtl/fifoStatCtrl.sv
module fifoStatCtrl
  import fifoStatPkg::*;
#(
  parameter int ADDRW = 4,
  parameter int DATAW = 16,
  parameter int LVLW  = 6
) (
  input  logic              regWrEn,
  input  logic [ADDRW-1:0]  regWrAddr,
  input  logic [ADDRW-1:0]  regRdAddr,
  input  logic [4:0]        statusWord,
  input  logic [LVLW-1:0]   txLevel,
  input  logic [LVLW-1:0]   rxLevel,
  input  logic [LVLW-1:0]   txThr,
  input  logic [LVLW-1:0]   rxThr,
  input  logic [NCAUSE-1:0] maskReg,
  input  logic [NCAUSE-1:0] rawStat,
  input  logic [NCAUSE-1:0] maskedStat,
  input  logic [1:0]        dmaCtrl,
  input  logic [LVLW-1:0]   txDl,
  input  logic [LVLW-1:0]   rxDl,
  output ctlStrobeT         ctl,
  output logic [DATAW-1:0]  regRdData
);

  always_comb begin
    ctl = '0;
    if (regWrEn) begin
      case (int'(regWrAddr))
        ADDR_TXTHR: ctl.wrTxThr = 1'b1;
        ADDR_RXTHR: ctl.wrRxThr = 1'b1;
        ADDR_MASK:  ctl.wrMask  = 1'b1;
        ADDR_CLEAR: ctl.wrClr   = 1'b1;
        ADDR_DMA:   ctl.wrDma   = 1'b1;
        ADDR_TXDL:  ctl.wrTxDl  = 1'b1;
        ADDR_RXDL:  ctl.wrRxDl  = 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    regRdData = '0;
    case (int'(regRdAddr))
      ADDR_STATUS: regRdData = DATAW'(statusWord);
      ADDR_TXLVL:  regRdData = DATAW'(txLevel);
      ADDR_RXLVL:  regRdData = DATAW'(rxLevel);
      ADDR_TXTHR:  regRdData = DATAW'(txThr);
      ADDR_RXTHR:  regRdData = DATAW'(rxThr);
      ADDR_MASK:   regRdData = DATAW'(maskReg);
      ADDR_RAW:    regRdData = DATAW'(rawStat);
      ADDR_MASKED: regRdData = DATAW'(maskedStat);
      ADDR_DMA:    regRdData = DATAW'(dmaCtrl);
      ADDR_TXDL:   regRdData = DATAW'(txDl);
      ADDR_RXDL:   regRdData = DATAW'(rxDl);
      default:     regRdData = '0;
    endcase
  end

endmodule

// File: rtl/fifoStatDp.sv
module fifoStatDp
  import fifoStatPkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DATAW = 16,
  parameter int LVLW  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobeT         ctl,
  input  logic [DATAW-1:0]  wrData,
  input  logic              busy,
  input  logic [LVLW-1:0]   txLevel,
  input  logic [LVLW-1:0]   rxLevel,
  input  logic              txPush,
  input  logic              rxPush,
  input  logic              rxPop,
  output logic [4:0]        statusWord,
  output logic [NCAUSE-1:0] rawStat,
  output logic [NCAUSE-1:0] maskedStat,
  output logic [NCAUSE-1:0] maskReg,
  output logic [1:0]        dmaCtrl,
  output logic [LVLW-1:0]   txThr,
  output logic [LVLW-1:0]   rxThr,
  output logic [LVLW-1:0]   txDl,
  output logic [LVLW-1:0]   rxDl,
  output logic              irq,
  output logic              txDmaReq,
  output logic              rxDmaReq
);

  localparam logic [LVLW-1:0]  FULLLVL = LVLW'(DEPTH);
  localparam logic [DATAW-1:0] LIMIT   = DATAW'(DEPTH);

  logic txOvf, rxUnd, rxOvf;
  logic txFullW, txEmptyW, rxFullW, rxEmptyW;
  logic fits;
  logic setTxOvf, setRxUnd, setRxOvf;
  logic clrTxOvf, clrRxUnd, clrRxOvf;

  assign txFullW  = (txLevel == FULLLVL);
  assign txEmptyW = (txLevel == '0);
  assign rxFullW  = (rxLevel == FULLLVL);
  assign rxEmptyW = (rxLevel == '0);

  assign statusWord = {rxFullW, rxEmptyW, txEmptyW, txFullW, busy};

  // values at or above depth are refused
  assign fits = (wrData < LIMIT);

  assign setTxOvf = txPush & txFullW;
  assign setRxUnd = rxPop  & rxEmptyW;
  assign setRxOvf = rxPush & rxFullW;
  assign clrTxOvf = ctl.wrClr & (wrData[0] | wrData[3]);
  assign clrRxUnd = ctl.wrClr & (wrData[0] | wrData[1]);
  assign clrRxOvf = ctl.wrClr & (wrData[0] | wrData[2]);

  assign rawStat    = {(rxLevel > rxThr), rxOvf, rxUnd, txOvf, (txLevel <= txThr)};
  assign maskedStat = rawStat & maskReg;

  assign txDmaReq = dmaCtrl[1] & (txLevel <= txDl);
  assign rxDmaReq = dmaCtrl[0] & (rxLevel > rxDl);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txThr   <= '0;
      rxThr   <= '0;
      txDl    <= '0;
      rxDl    <= '0;
      maskReg <= '0;
      dmaCtrl <= '0;
      txOvf   <= 1'b0;
      rxUnd   <= 1'b0;
      rxOvf   <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (ctl.wrTxThr && fits) txThr <= wrData[LVLW-1:0];
      if (ctl.wrRxThr && fits) rxThr <= wrData[LVLW-1:0];
      if (ctl.wrTxDl  && fits) txDl  <= wrData[LVLW-1:0];
      if (ctl.wrRxDl  && fits) rxDl  <= wrData[LVLW-1:0];
      if (ctl.wrMask) maskReg <= wrData[NCAUSE-1:0];
      if (ctl.wrDma)  dmaCtrl <= wrData[1:0];
      txOvf <= setTxOvf | (txOvf & ~clrTxOvf);
      rxUnd <= setRxUnd | (rxUnd & ~clrRxUnd);
      rxOvf <= setRxOvf | (rxOvf & ~clrRxOvf);
      irq   <= |maskedStat;
    end
  end

  // R2: stored levels always stay below the depth
  a_r2_thr_in_range: assert property (@(posedge clk) disable iff (!rstN)
    (txThr < FULLLVL) && (rxThr < FULLLVL) && (txDl < FULLLVL) && (rxDl < FULLLVL));

  // R5: push into a full transmit FIFO leaves the overflow cause set
  a_r5_tx_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (txPush && txLevel == FULLLVL) |=> rawStat[1]);

  // R6: pop from an empty receive FIFO leaves the underflow cause set
  a_r6_rx_und_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (rxPop && rxLevel == '0) |=> rawStat[2]);

  // R7: clear-all with no fault event empties the sticky causes
  a_r7_clear_all: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wrClr && wrData[0] && !txPush && !rxPush && !rxPop) |=> (rawStat[3:1] == 3'b000));

  // R9: an all-zero mask keeps the line low on the next cycle
  a_r9_irq_masked_off: assert property (@(posedge clk) disable iff (!rstN)
    (maskReg == '0) |=> !irq);

  // R10: a transmit request never comes with a full FIFO or disabled DMA
  a_r10_tx_dma_sane: assert property (@(posedge clk) disable iff (!rstN)
    txDmaReq |-> (dmaCtrl[1] && !statusWord[1]));

endmodule

// File: rtl/fifoStatUnit.sv
module fifoStatUnit
  import fifoStatPkg::*;
#(
  parameter int DEPTH = 32,
  parameter int ADDRW = 4,
  parameter int DATAW = 16,
  parameter int LVLW  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busy,
  input  logic [LVLW-1:0]  txLevel,
  input  logic [LVLW-1:0]  rxLevel,
  input  logic             txPush,
  input  logic             rxPush,
  input  logic             rxPop,
  input  logic             regWrEn,
  input  logic [ADDRW-1:0] regWrAddr,
  input  logic [DATAW-1:0] regWrData,
  input  logic [ADDRW-1:0] regRdAddr,
  output logic [DATAW-1:0] regRdData,
  output logic [4:0]       statusWord,
  output logic             irq,
  output logic             txDmaReq,
  output logic             rxDmaReq
);

  ctlStrobeT         ctl;
  logic [NCAUSE-1:0] rawStat, maskedStat, maskReg;
  logic [1:0]        dmaCtrl;
  logic [LVLW-1:0]   txThr, rxThr, txDl, rxDl;

  fifoStatCtrl #(.ADDRW(ADDRW), .DATAW(DATAW), .LVLW(LVLW)) uCtrl (
    .regWrEn    (regWrEn),
    .regWrAddr  (regWrAddr),
    .regRdAddr  (regRdAddr),
    .statusWord (statusWord),
    .txLevel    (txLevel),
    .rxLevel    (rxLevel),
    .txThr      (txThr),
    .rxThr      (rxThr),
    .maskReg    (maskReg),
    .rawStat    (rawStat),
    .maskedStat (maskedStat),
    .dmaCtrl    (dmaCtrl),
    .txDl       (txDl),
    .rxDl       (rxDl),
    .ctl        (ctl),
    .regRdData  (regRdData)
  );

  fifoStatDp #(.DEPTH(DEPTH), .DATAW(DATAW), .LVLW(LVLW)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .wrData     (regWrData),
    .busy       (busy),
    .txLevel    (txLevel),
    .rxLevel    (rxLevel),
    .txPush     (txPush),
    .rxPush     (rxPush),
    .rxPop      (rxPop),
    .statusWord (statusWord),
    .rawStat    (rawStat),
    .maskedStat (maskedStat),
    .maskReg    (maskReg),
    .dmaCtrl    (dmaCtrl),
    .txThr      (txThr),
    .rxThr      (rxThr),
    .txDl       (txDl),
    .rxDl       (rxDl),
    .irq        (irq),
    .txDmaReq   (txDmaReq),
    .rxDmaReq   (rxDmaReq)
  );

endmodule

// File: tb/fifoStatUnit_test.sv
module fifoStatUnit_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;
  localparam int ADDRW = 4;
  localparam int DATAW = 16;
  localparam int LVLW  = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rstN;
  logic             busy;
  logic [LVLW-1:0]  txLevel, rxLevel;
  logic             txPush, rxPush, rxPop;
  logic             regWrEn;
  logic [ADDRW-1:0] regWrAddr, regRdAddr;
  logic [DATAW-1:0] regWrData;
  logic [DATAW-1:0] regRdData;
  logic [4:0]       statusWord;
  logic             irq, txDmaReq, rxDmaReq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference register state
  int mTxThr, mRxThr, mTxDl, mRxDl, mMask, mDma;
  bit mTxOvf, mRxUnd, mRxOvf;
  bit expIrq;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifoStatUnit #(.DEPTH(DEPTH), .ADDRW(ADDRW), .DATAW(DATAW)) uut (
    .clk(clk), .rstN(rstN), .busy(busy), .txLevel(txLevel), .rxLevel(rxLevel),
    .txPush(txPush), .rxPush(rxPush), .rxPop(rxPop), .regWrEn(regWrEn),
    .regWrAddr(regWrAddr), .regWrData(regWrData), .regRdAddr(regRdAddr),
    .regRdData(regRdData), .statusWord(statusWord), .irq(irq),
    .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int expStatus();
    return {27'b0, (int'(rxLevel) == DEPTH), (rxLevel == 0), (txLevel == 0),
            (int'(txLevel) == DEPTH), busy};
  endfunction

  function automatic int expRaw();
    return {27'b0, (int'(rxLevel) > mRxThr), mRxOvf, mRxUnd, mTxOvf, (int'(txLevel) <= mTxThr)};
  endfunction

  function automatic int expRd(int a);
    case (a)
      0:  return expStatus();
      1:  return int'(txLevel);
      2:  return int'(rxLevel);
      3:  return mTxThr;
      4:  return mRxThr;
      5:  return mMask;
      6:  return expRaw();
      7:  return expRaw() & mMask;
      9:  return mDma;
      10: return mTxDl;
      11: return mRxDl;
      default: return 0;
    endcase
  endfunction

  function automatic string rdReq(int a);
    case (a)
      0: return "R1";
      1, 2: return "R1";
      3, 4, 10, 11: return "R2";
      5, 7: return "R8";
      6: return "R3";
      default: return "R7";
    endcase
  endfunction

  // one cycle: drive, check combinational outputs, update model, clock
  task automatic step(bit we, int wa, int wd, int ra, int txl, int rxl,
                      bit tp, bit rp, bit rpo, bit bz);
    bit nextIrq;
    bit fitsV;
    @(negedge clk);
    regWrEn = we; regWrAddr = ADDRW'(wa); regWrData = DATAW'(wd);
    regRdAddr = ADDRW'(ra); txLevel = LVLW'(txl); rxLevel = LVLW'(rxl);
    txPush = tp; rxPush = rp; rxPop = rpo; busy = bz;
    #1;
    check("R1 status", int'(statusWord), expStatus());
    check("R9 irq", int'(irq), int'(expIrq));
    check("R10 txDmaReq", int'(txDmaReq), int'(mDma[1] && txl <= mTxDl));
    check("R10 rxDmaReq", int'(rxDmaReq), int'(mDma[0] && rxl > mRxDl));
    check(rdReq(ra), int'(regRdData), expRd(ra));
    nextIrq = ((expRaw() & mMask) != 0);
    fitsV = (wd < DEPTH);
    if (we) begin
      case (wa)
        3:  if (fitsV) mTxThr = wd;
        4:  if (fitsV) mRxThr = wd;
        10: if (fitsV) mTxDl = wd;
        11: if (fitsV) mRxDl = wd;
        5:  mMask = wd & 31;
        9:  mDma = wd & 3;
        8: begin
          if (wd[0] || wd[3]) mTxOvf = 0;
          if (wd[0] || wd[1]) mRxUnd = 0;
          if (wd[0] || wd[2]) mRxOvf = 0;
        end
        default: ;
      endcase
    end
    if (tp && txl == DEPTH) mTxOvf = 1;
    if (rpo && rxl == 0) mRxUnd = 1;
    if (rp && rxl == DEPTH) mRxOvf = 1;
    @(posedge clk);
    expIrq = nextIrq;
  endtask

  function automatic int pickLevel();
    int c = $urandom_range(0, 3);
    if (c == 0) return 0;
    if (c == 1) return DEPTH;
    return $urandom_range(0, DEPTH);
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    rstN = 0; busy = 0; txLevel = 0; rxLevel = 0; txPush = 0; rxPush = 0; rxPop = 0;
    regWrEn = 0; regWrAddr = 0; regWrData = 0; regRdAddr = 0;
    mTxThr = 0; mRxThr = 0; mTxDl = 0; mRxDl = 0; mMask = 0; mDma = 0;
    mTxOvf = 0; mRxUnd = 0; mRxOvf = 0; expIrq = 0;
    // dirty the registers with writes during reset: they must stay zero
    regWrEn = 1; regWrAddr = 5; regWrData = 16'h1f;
    repeat (3) @(posedge clk);
    regWrEn = 0;
    @(negedge clk);
    // R11: reset state
    check("R11 irq", int'(irq), 0);
    check("R11 txDmaReq", int'(txDmaReq), 0);
    check("R11 rxDmaReq", int'(rxDmaReq), 0);
    for (int a = 0; a < 12; a++) begin
      regRdAddr = ADDRW'(a);
      #1;
      check("R11 register", int'(regRdData), expRd(a));
    end
    @(negedge clk);
    rstN = 1;

    // R2: depth probe on the transmit threshold
    for (int v = 2; v <= DEPTH + 2; v++) begin
      step(1, 3, v, 3, 5, 5, 0, 0, 0, 0);
      step(0, 0, 0, 3, 5, 5, 0, 0, 0, 0);
    end
    // R2: probe on the receive DMA level
    step(1, 11, DEPTH - 1, 11, 0, 0, 0, 0, 0, 0);
    step(1, 11, DEPTH, 11, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 11, 0, 0, 0, 0, 0, 0);

    // R5, R6, R7: directed sticky set and selective clear
    step(1, 5, 31, 6, DEPTH, 0, 1, 0, 1, 1);
    step(0, 0, 0, 6, 0, DEPTH, 0, 1, 0, 0);
    step(0, 0, 0, 7, 0, 3, 0, 0, 0, 0);
    step(1, 8, 8, 6, 0, 3, 0, 0, 0, 0);
    step(1, 8, 2, 6, 0, 3, 0, 0, 0, 0);
    step(1, 8, 1, 6, DEPTH, 3, 1, 0, 0, 0);  // R7: set wins over clear
    step(1, 8, 1, 6, 4, 3, 0, 0, 0, 0);
    step(0, 0, 0, 6, 4, 3, 0, 0, 0, 0);

    // R10: DMA requests at their boundaries
    step(1, 10, 7, 10, 8, 0, 0, 0, 0, 0);
    step(1, 9, 3, 9, 8, 0, 0, 0, 0, 0);
    step(1, 11, 4, 9, 7, 4, 0, 0, 0, 0);
    step(0, 0, 0, 9, 7, 5, 0, 0, 0, 0);
    step(0, 0, 0, 9, 8, 4, 0, 0, 0, 0);

    // R3, R4, R8, R9: random mix
    for (int i = 0; i < 4000; i++) begin
      int wa, wd, c;
      c = $urandom_range(0, 3);
      wa = $urandom_range(0, 12);
      if (wa == 3 || wa == 4 || wa == 10 || wa == 11) wd = $urandom_range(0, DEPTH + 4);
      else if (wa == 8) wd = $urandom_range(0, 15);
      else wd = $urandom_range(0, 65535);
      step(c == 0, wa, wd, $urandom_range(0, 13), pickLevel(), pickLevel(),
           ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0),
           ($urandom_range(0, 3) == 0), ($urandom_range(0, 1) == 1));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule